// File: doc/BRIEF.md
# Keyed Dual-Mode Correlation Array

This block evaluates one three-output slice of a prime-length (13-point) type-IV cosine or sine transform. The slice is the sum of two 3x3 cyclic matrix-vector products, one per triad of processing elements. The block takes six auxiliary samples in one cycle: three for the upper triad and three for the lower triad. It returns three rounded results on consecutive cycles. One mode bit selects the cosine or the sine coefficient set, and the datapath stays the same in both modes.

Each processing element multiplies its held sample by a Q1.14 coefficient. It then adds or subtracts the product on a partial sum that moves one element per clock. The add-or-subtract choice comes from a nominal sign for the transform. That sign is inverted wherever the key bit for that element and output row differs from a reference bit. The reference bit pattern rotates by one position on every output row. Three six-bit keys are supplied, one per output row. Only the right keys, given in the right order, produce the true transform slice. Any other key set still produces outputs at the same latency, but some partial products carry the wrong sign.

Top module: `corr_keyed_array`

## Requirements
- R1: Output row j (j = 0, 1, 2) is the sum over element p = 3*t + i (triad t, column i) of sign times in_smp[p] times coef(idx). Here idx is taken from {4, 3, 12} for t = 0 and from {8, 6, 11} for t = 1, at position (i + j) mod 3.
- R2: The coefficient for index n is round(2^14 * 2cos(n*pi/26)) when in_mode = 0, and round(2^14 * 2sin(n*pi/26)) when in_mode = 1. The values are n=3: 30639 / 11620, n=4: 29015 / 15228, n=6: 24527 / 21729, n=8: 18614 / 26968, n=11: 7842 / 31816, n=12: 3950 / 32529.
- R3: Nominal sign. In cosine mode a term is negated when i + j = 2. In sine mode a term is negated when i + j > 2.
- R4: Row j uses key in_key[j], and bit p of that key belongs to element p. The reference bit for element p on row j is 1 exactly when i = (j + 2) mod 3. This gives 6'b100100, 6'b001001 and 6'b010010 for rows 0, 1 and 2. Each key bit that differs from its reference inverts the sign of that element's term on that row.
- R5: The sum, which carries 14 fraction bits, has 2^13 added to it. It is then shifted right arithmetically by 14 bits and saturated to the range -32768..32767.
- R6: Rows 0, 1 and 2 appear on out_data in three consecutive cycles with out_valid high and out_idx equal to 0, 1 and 2. Row 0 appears 7 cycles after the cycle in which in_valid was accepted.
- R7: in_valid is accepted only when no block is being issued. In the two cycles after an acceptance, in_valid is ignored. A block offered on the third cycle is accepted, and its rows follow the previous rows with no gap.
- R8: While out_valid is low, out_data keeps its last value.
- R9: While reset is applied and after it, with no block accepted, out_valid = 0, out_idx = 0 and out_data = 0.
- R10: Samples, mode and keys are taken in the acceptance cycle. Changing them in later cycles does not alter that block's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Offers a block of six samples |
| in_mode | input | 1 | 0 selects cosine coefficients, 1 selects sine coefficients |
| in_smp | input | 6x16 | Signed samples; entries 0..2 feed the upper triad, entries 3..5 the lower triad |
| in_key | input | 3x6 | One key per output row, in_key[j] for row j |
| out_valid | output | 1 | High for each result row |
| out_idx | output | 2 | Row index of the current result |
| out_data | output | 16 | Rounded, saturated signed result |

## Verification
A wrong coefficient, sign tag or key reference shows as a wrong value on out_data. It appears in exactly the result row whose output index matches the bad row, 7 to 9 cycles after acceptance. A misaligned input skew or partial-sum pipeline mixes samples from neighbouring blocks. This is exposed by back-to-back blocks, and by driving garbage on the inputs right after each acceptance. A wrong issue counter shows as missing, extra or out-of-order out_idx values.

// File: rtl/corr_pkg.sv
// Shared types and constant functions for the keyed correlation array.
// Assumes a fixed 3x3 cyclic slice of a 13-point transform, with Q1.14 coefficients.
package corr_pkg;

    localparam int COEF_W = 16;
    localparam int KEY_W  = 6;

    // Wavefront tag that travels with each partial sum
    typedef struct packed {
        logic             vld;
        logic [1:0]       row;
        logic             mode;
        logic [KEY_W-1:0] key;
    } corr_tag_t;

    // Coefficient index for element (triad, col) on a given output row
    function automatic logic [3:0] coef_index(int triad, int col, logic [1:0] row);
        int pos;
        pos = (col + int'(row)) % 3;
        if (triad == 0) return (pos == 0) ? 4'd4 : (pos == 1) ? 4'd3 : 4'd12;
        return (pos == 0) ? 4'd8 : (pos == 1) ? 4'd6 : 4'd11;
    endfunction

    // Q1.14 value of 2cos(n*pi/26), or of 2sin(n*pi/26) when sin_mode is set
    function automatic logic signed [COEF_W-1:0] coef_q14(logic sin_mode, logic [3:0] idx);
        case (idx)
            4'd3:    return sin_mode ? 16'sd11620 : 16'sd30639;
            4'd4:    return sin_mode ? 16'sd15228 : 16'sd29015;
            4'd6:    return sin_mode ? 16'sd21729 : 16'sd24527;
            4'd8:    return sin_mode ? 16'sd26968 : 16'sd18614;
            4'd11:   return sin_mode ? 16'sd31816 : 16'sd7842;
            4'd12:   return sin_mode ? 16'sd32529 : 16'sd3950;
            default: return 16'sd0;
        endcase
    endfunction

    // Nominal (true-transform) sign: 1 means the term is subtracted
    function automatic logic nominal_neg(logic sin_mode, int col, logic [1:0] row);
        int s;
        s = col + int'(row);
        return sin_mode ? (s > 2) : (s == 2);
    endfunction

    // Reference key bit: the single set bit per triad rotates with the row
    function automatic logic ref_key_bit(int col, logic [1:0] row);
        return col == ((int'(row) + 2) % 3);
    endfunction

endpackage

// File: rtl/corr_pe.sv
// One processing element of the systolic array. It loads its operand when the
// row-0 wavefront arrives, then for every passing row it adds or subtracts
// operand*coef on the incoming partial sum. The sign is the nominal sign,
// inverted where the row's key bit differs from its reference bit.
// Assumes a row-0 tag and its sample arrive in the same cycle.
module corr_pe
    import corr_pkg::*;
#(
    parameter int W     = 16,
    parameter int ACC_W = 35,
    parameter int COL   = 0,
    parameter int TRIAD = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  corr_tag_t               tag_i,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [W-1:0]     smp_i,
    output corr_tag_t               tag_o,
    output logic signed [ACC_W-1:0] acc_o
);

    localparam int KB = TRIAD * 3 + COL;
    localparam int PW = W + COEF_W;

    logic signed [W-1:0]      smp_q;
    logic signed [W-1:0]      opd;
    logic signed [COEF_W-1:0] cf;
    logic signed [PW-1:0]     prod;
    logic signed [ACC_W-1:0]  ext;
    logic signed [ACC_W-1:0]  term;
    logic                     ld;
    logic                     neg;
    logic                     trig;

    // Select operand, coefficient and the keyed sign for the passing row
    always_comb begin
        ld   = tag_i.vld && (tag_i.row == 2'd0);
        opd  = ld ? smp_i : smp_q;
        cf   = coef_q14(tag_i.mode, coef_index(TRIAD, COL, tag_i.row));
        trig = tag_i.vld;
        neg  = nominal_neg(tag_i.mode, COL, tag_i.row)
             ^ (trig & (tag_i.key[KB] ^ ref_key_bit(COL, tag_i.row)));
        prod = opd * cf;
        ext  = ACC_W'(prod);
        term = neg ? -ext : ext;
    end

    // Register the partial sum and tag for the next element; hold the operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_o <= '0;
            acc_o <= '0;
            smp_q <= '0;
        end else begin
            tag_o <= tag_i;
            acc_o <= acc_i + term;
            if (ld) smp_q <= smp_i;
        end
    end

endmodule

// File: rtl/corr_row_issue.sv
// Issues the three row wavefronts of a block into the first element. Row 0
// leaves in the acceptance cycle, using the ports directly; rows 1 and 2 use the
// mode and keys captured at acceptance. Offers made while rows are still being
// issued are not taken.
module corr_row_issue
    import corr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_mode,
    input  logic [2:0][KEY_W-1:0]      in_key,
    output logic                       fire,
    output corr_tag_t                  tag_o
);

    logic [1:0]             cnt;
    logic                   mode_q;
    logic [2:0][KEY_W-1:0]  key_q;

    // Build the wavefront tag for this cycle
    always_comb begin
        fire  = rst_n && in_valid && (cnt == 2'd0);
        tag_o = '0;
        if (fire) begin
            tag_o = '{vld: 1'b1, row: 2'd0, mode: in_mode, key: in_key[0]};
        end else if (cnt != 2'd0) begin
            tag_o = '{vld: 1'b1, row: cnt, mode: mode_q, key: key_q[cnt]};
        end
    end

    // Row counter and capture of mode and keys at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= 2'd0;
            mode_q <= 1'b0;
            key_q  <= '0;
        end else if (fire) begin
            cnt    <= 2'd1;
            mode_q <= in_mode;
            key_q  <= in_key;
        end else if (cnt == 2'd2) begin
            cnt <= 2'd0;
        end else if (cnt != 2'd0) begin
            cnt <= cnt + 2'd1;
        end
    end

endmodule

// File: rtl/corr_out_round.sv
// Output stage: rounds the full-width sum to W bits (adding half an LSB, then
// shifting arithmetically), saturates it, and registers it with its row index.
// The data is held while no row arrives.
module corr_out_round #(
    parameter int W     = 16,
    parameter int ACC_W = 35,
    parameter int FRAC  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic [1:0]              row_i,
    input  logic signed [ACC_W-1:0] acc_i,
    output logic                    out_valid,
    output logic [1:0]              out_idx,
    output logic [W-1:0]            out_data
);

    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(2 ** (FRAC - 1));
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (W - 1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] shr;
    logic signed [ACC_W-1:0] sat;

    // Round half up, then clamp to the output range
    always_comb begin
        rnd = acc_i + HALF;
        shr = rnd >>> FRAC;
        if (shr > SAT_HI)      sat = SAT_HI;
        else if (shr < SAT_LO) sat = SAT_LO;
        else                   sat = shr;
    end

    // Register the result row; hold the data between rows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= 2'd0;
            out_data  <= '0;
        end else begin
            out_valid <= vld_i;
            if (vld_i) begin
                out_idx  <= row_i;
                out_data <= sat[W-1:0];
            end
        end
    end

endmodule

// File: rtl/corr_keyed_array.sv
// Top of the keyed dual-mode correlation array: a row issuer, an input skew
// line, six processing elements in two triads, and a rounding output stage.
// The sample for element k is delayed k cycles so that it meets the row-0 wavefront.
// Latency from acceptance to row 0 is NPE + 1 cycles.
module corr_keyed_array
    import corr_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_mode,
    input  logic [5:0][W-1:0]       in_smp,
    input  logic [2:0][KEY_W-1:0]   in_key,
    output logic                    out_valid,
    output logic [1:0]              out_idx,
    output logic [W-1:0]            out_data
);

    localparam int TRI   = 3;
    localparam int NPE   = 2 * TRI;
    localparam int ACC_W = W + COEF_W + 3;

    corr_tag_t                pe_tag [NPE+1];
    logic signed [ACC_W-1:0]  pe_acc [NPE+1];
    logic signed [W-1:0]      pe_smp [NPE];
    logic                     issue_fire;

    assign pe_acc[0] = '0;

    corr_row_issue u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_mode  (in_mode),
        .in_key   (in_key),
        .fire     (issue_fire),
        .tag_o    (pe_tag[0])
    );

    for (genvar k = 0; k < NPE; k++) begin : g_pe
        if (k == 0) begin : g_direct
            assign pe_smp[k] = $signed(in_smp[k]);
        end else begin : g_skew
            logic signed [W-1:0] sr [k];
            // Skew line delaying this element's sample by k cycles
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int d = 0; d < k; d++) sr[d] <= '0;
                end else begin
                    sr[0] <= $signed(in_smp[k]);
                    for (int d = 1; d < k; d++) sr[d] <= sr[d-1];
                end
            end
            assign pe_smp[k] = sr[k-1];
        end

        corr_pe #(
            .W     (W),
            .ACC_W (ACC_W),
            .COL   (k % TRI),
            .TRIAD (k / TRI)
        ) u_pe (
            .clk   (clk),
            .rst_n (rst_n),
            .tag_i (pe_tag[k]),
            .acc_i (pe_acc[k]),
            .smp_i (pe_smp[k]),
            .tag_o (pe_tag[k+1]),
            .acc_o (pe_acc[k+1])
        );
    end

    corr_out_round #(
        .W     (W),
        .ACC_W (ACC_W),
        .FRAC  (FRAC)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (pe_tag[NPE].vld),
        .row_i     (pe_tag[NPE].row),
        .acc_i     (pe_acc[NPE]),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_data  (out_data)
    );

endmodule

// File: rtl/corr_keyed_array_chk.sv
// Timing and ordering properties of the keyed correlation array, bound to its top.
// Assumes the array has six elements, so the last tag lags acceptance by 6 cycles.
module corr_keyed_array_chk
    import corr_pkg::*;
#(
    parameter int W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_mode,
    input logic [KEY_W-1:0]      in_key0,
    input logic                  fire,
    input corr_tag_t             fin_tag,
    input logic                  out_valid,
    input logic [1:0]            out_idx,
    input logic [W-1:0]          out_data
);

    AST_FIRST_ROW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire, 7) |-> out_valid && out_idx == 2'd0); // R6

    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_idx != 2'd2 |=> out_valid && out_idx == $past(out_idx) + 2'd1); // R6

    AST_BLOCK_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_idx) == 2'd2); // R6

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire ##1 !fire); // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R8

    AST_CAPTURE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire, 6) |-> fin_tag.vld && fin_tag.row == 2'd0
                           && fin_tag.key == $past(in_key0, 6)
                           && fin_tag.mode == $past(in_mode, 6)); // R10

endmodule

bind corr_keyed_array corr_keyed_array_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_mode   (in_mode),
    .in_key0   (in_key[0]),
    .fire      (issue_fire),
    .fin_tag   (pe_tag[6]),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_data  (out_data)
);

// File: tb/test_corr_keyed_array.sv
// Self-checking bench for corr_keyed_array: impulse sweeps in both modes,
// key order and key bit sweeps, saturation corners, and back-to-back random blocks.
module test_corr_keyed_array;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_mode = 1'b0;
    logic [5:0][15:0]    in_smp = '0;
    logic [2:0][5:0]     in_key = '0;
    logic                out_valid;
    logic [1:0]          out_idx;
    logic [15:0]         out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int    exp_d [512];
    int    exp_c [512];
    int    exp_i [512];
    string exp_r [512];
    int    exp_n = 0;
    int    got_d [512];
    int    got_c [512];
    int    got_i [512];
    int    got_n = 0;

    localparam bit [5:0] KEY_OK [3] = '{6'b100100, 6'b001001, 6'b010010};

    corr_keyed_array i_corr_keyed_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_smp    (in_smp),
        .in_key    (in_key),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_data  (out_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every result row with its cycle number
    always @(negedge clk) begin
        if (rst_n && out_valid && got_n < 512) begin
            got_d[got_n] = int'($signed(out_data));
            got_i[got_n] = int'(out_idx);
            got_c[got_n] = cyc;
            got_n = got_n + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // R2 coefficient table
    function automatic longint coef_b(bit sinm, int n);
        case (n)
            3:  return sinm ? 11620 : 30639;
            4:  return sinm ? 15228 : 29015;
            6:  return sinm ? 21729 : 24527;
            8:  return sinm ? 26968 : 18614;
            11: return sinm ? 31816 : 7842;
            12: return sinm ? 32529 : 3950;
            default: return 0;
        endcase
    endfunction

    // R1, R3, R4, R5 arithmetic model of one output row
    function automatic int model(bit m, int x[6], bit [5:0] k[3], int j);
        longint s = 0;
        longint r;
        for (int p = 0; p < 6; p++) begin
            int t = p / 3;
            int i = p % 3;
            int pos = (i + j) % 3;
            int n;
            bit neg;
            longint term;
            if (t == 0) n = (pos == 0) ? 4 : (pos == 1) ? 3 : 12;
            else        n = (pos == 0) ? 8 : (pos == 1) ? 6 : 11;
            neg = m ? (i + j > 2) : (i + j == 2);
            if (k[j][p] != (i == (j + 2) % 3)) neg = !neg;
            term = longint'(x[p]) * coef_b(m, n);
            s += neg ? -term : term;
        end
        r = (s + 8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Present one block at the current negedge and log its expected rows
    task automatic drive(bit m, int x[6], bit [5:0] k[3], string req);
        in_valid = 1'b1;
        in_mode  = m;
        for (int p = 0; p < 6; p++) in_smp[p] = x[p][15:0];
        for (int j = 0; j < 3; j++) in_key[j] = k[j];
        for (int j = 0; j < 3; j++) begin
            exp_d[exp_n] = model(m, x, k, j);
            exp_i[exp_n] = j;
            exp_c[exp_n] = cyc + 7 + j;
            exp_r[exp_n] = req;
            exp_n++;
        end
    endtask

    // Scramble every input other than in_valid (R10)
    task automatic scramble();
        in_mode = ~in_mode;
        for (int p = 0; p < 6; p++) in_smp[p] = 16'($urandom);
        for (int j = 0; j < 3; j++) in_key[j] = 6'($urandom);
    endtask

    // Wait out the pipeline, then compare recorded rows with expected ones
    task automatic settle_and_compare(int wait_cyc);
        int lim;
        repeat (wait_cyc) @(negedge clk);
        chk(got_n == exp_n, "R6", "row count", got_n, exp_n);
        lim = (got_n < exp_n) ? got_n : exp_n;
        for (int e = 0; e < lim; e++) begin
            chk(got_d[e] == exp_d[e], exp_r[e], "row data", got_d[e], exp_d[e]);
            chk(got_i[e] == exp_i[e], "R6", "row index", got_i[e], exp_i[e]);
            chk(got_c[e] == exp_c[e], "R6", "row cycle", got_c[e], exp_c[e]);
        end
        got_n = 0;
        exp_n = 0;
    endtask

    // Single block with garbage on the inputs afterwards
    task automatic one_block(bit m, int x[6], bit [5:0] k[3], string req);
        @(negedge clk);
        drive(m, x, k, req);
        @(negedge clk);
        in_valid = 1'b0;
        scramble();
        settle_and_compare(12);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int        x[6];
        bit [5:0]  k[3];
        bit [5:0]  kp[3];
        int        last;
        int        perm [6][3];

        perm = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

        // R9 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        chk(out_data == 16'd0, "R9", "out_data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        chk(out_idx == 2'd0, "R9", "out_idx after reset", int'(out_idx), 0);
        chk(out_data == 16'd0, "R9", "out_data after reset", int'(out_data), 0);

        // R1 R2 R3 impulse sweep, both modes, correct keys
        k = KEY_OK;
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 6; p++) begin
                for (int q = 0; q < 6; q++) x[q] = 0;
                x[p] = (p % 2 == 0) ? 16384 : -9000;
                one_block(bit'(m), x, k, m == 0 ? "R1" : "R2");
            end
        end

        // R4 key order sweep: all six orders of the reference keys
        x = '{1234, -2222, 3000, -4100, 500, 7777};
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 6; o++) begin
                for (int j = 0; j < 3; j++) kp[j] = KEY_OK[perm[o][j]];
                one_block(bit'(m), x, kp, "R4");
            end
        end

        // R4 single key bit flips on the correct keys
        for (int j = 0; j < 3; j++) begin
            for (int b = 0; b < 6; b++) begin
                kp = KEY_OK;
                kp[j][b] = ~kp[j][b];
                one_block(bit'(b % 2), x, kp, "R4");
            end
        end

        // R5 saturation and rounding corners
        x = '{32767, 32767, 32767, 32767, 32767, 32767};
        one_block(1'b1, x, KEY_OK, "R5");
        kp = '{6'b011011, 6'b110110, 6'b101101};
        one_block(1'b1, x, kp, "R5");
        x = '{-32768, -32768, -32768, -32768, -32768, -32768};
        one_block(1'b0, x, KEY_OK, "R5");
        one_block(1'b1, x, kp, "R5");
        x = '{1, 0, 0, 0, 0, -1};
        one_block(1'b0, x, KEY_OK, "R5");

        // R8 output held while idle
        last = int'(out_data);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", "out_valid idle", int'(out_valid), 0);
            chk(int'(out_data) == last, "R8", "out_data idle", int'(out_data), last);
        end

        // R7 R10 back-to-back blocks with in_valid held high and garbage on busy cycles
        for (int b = 0; b < 40; b++) begin
            bit m;
            @(negedge clk);
            for (int p = 0; p < 6; p++) x[p] = int'($urandom % 65536) - 32768;
            for (int j = 0; j < 3; j++) kp[j] = (b % 3 == 0) ? KEY_OK[j] : 6'($urandom);
            m = bit'($urandom % 2);
            drive(m, x, kp, "R7");
            @(negedge clk);
            scramble();
            @(negedge clk);
            scramble();
        end
        @(negedge clk);
        in_valid = 1'b0;
        settle_and_compare(14);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule